// File: doc/BRIEF.md
# x1 Asynchronous DRAM Device Model

This block is a synthesizable stand-in for a single-bit-wide dynamic memory seen from its pins. A controller under test drives a multiplexed address bus, active-low row and column strobes, an active-low write control and a data-in bit. The model returns one data-out bit plus an enable that says when that bit would be driven. An enclosing testbench or FPGA wrapper can turn that pair into a tristate pin. No internal tristate is used, so the block stays synthesizable.

The strobe pins are asynchronous in spirit. Here they are sampled by a free-running system clock, and their edges are found from consecutive samples. The row is captured when the row strobe falls. The column is captured when the column strobe falls with the row strobe low. The write control decides the cycle type. If it is low at the column strobe edge, the cycle is an early write and the output stays quiet. Otherwise the cycle reads, and a later fall of the write control writes the cell while the output keeps showing it. Row-strobe cycles that never lower the column strobe act as refresh and touch nothing. All pins are plain control and data signals, so no valid/ready handshake applies; each pin's level at the sampling clock edge is its meaning.

Top module: `dram_x1_model`

## Requirements
- R1: After reset, q_oe is 0 and every cell of the 2^(ROW_W+COL_W) bit array reads 0.
- R2: The row is taken from addr when ras_n falls, and the column when cas_n falls with ras_n low. The cell index is row*2^COL_W + column, so swapping row and column selects a different cell.
- R3: q_oe is 0 whenever cas_n has been high for two consecutive clock samples.
- R4: In a read cycle (we_n high when cas_n falls), q_oe stays 0 for the first ACCESS_CYC clocks after cas_n is sampled low. It is 1 by ACCESS_CYC+3 clocks, and q then carries the addressed bit. It stays 1 until cas_n rises, even if ras_n rises first.
- R5: If we_n is low when cas_n falls (early write), the bit on d is stored in the addressed cell and q_oe stays 0 for the whole cycle.
- R6: If we_n falls while cas_n is low in a read cycle (late write), the bit on d is stored in the cell. q_oe stays 1, and q shows the new value within three clocks.
- R7: A ras_n low period with cas_n held high changes no cell, and q_oe stays 0, whatever we_n and d do.
- R8: With ras_n held low, each further cas_n fall selects a new column of the captured row for a read or a write.
- R9: A cas_n fall while ras_n is high starts no access: no cell is written and q_oe stays 0.
- R10: Toggling ras_n high and then low again while cas_n stays low leaves q_oe at 1 and q on the originally addressed cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the strobe timing |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low; also gates the output |
| we_n | input | 1 | Write control, low selects write |
| addr | input | ADDR_W | Multiplexed row/column address |
| d | input | 1 | Write data bit |
| q | output | 1 | Read data bit (0 when q_oe is 0) |
| q_oe | output | 1 | High when q would be driven onto the pin |

## Verification
On every cycle, the embedded assertions check the following. The output enable is off once the column strobe has been high for two samples. It is never on outside a read-type cycle, and never during an early write. It holds steady while the column strobe stays low. Writes happen only with the column strobe low, and each write lands in the cell it named. A column edge with the row strobe high opens no access. The stored values themselves, the row/column split, refresh leaving data intact, page-mode column changes, the access delay and the hidden-refresh case are shown only by the bench's scenarios, which read cells back through the pins.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_READ   = 2'd1,
    CYC_EWRITE = 2'd2
  } cyc_kind_t;
endpackage

// File: rtl/dram_pin_sampler.sv
module dram_pin_sampler #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              d,
  output logic              ras_s,
  output logic              cas_s,
  output logic              we_s,
  output logic [ADDR_W-1:0] addr_s,
  output logic              d_s,
  output logic              ras_fall,
  output logic              cas_fall,
  output logic              we_fall
);
  logic ras_p, cas_p, we_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_s  <= 1'b1;
      cas_s  <= 1'b1;
      we_s   <= 1'b1;
      ras_p  <= 1'b1;
      cas_p  <= 1'b1;
      we_p   <= 1'b1;
      addr_s <= '0;
      d_s    <= 1'b0;
    end else begin
      ras_s  <= ras_n;
      cas_s  <= cas_n;
      we_s   <= we_n;
      ras_p  <= ras_s;
      cas_p  <= cas_s;
      we_p   <= we_s;
      addr_s <= addr;
      d_s    <= d;
    end
  end

  // strobes are active low: a fall is high-then-low between two samples
  assign ras_fall = ras_p & ~ras_s;
  assign cas_fall = cas_p & ~cas_s;
  assign we_fall  = we_p  & ~we_s;
endmodule

// File: rtl/dram_bit_array.sv
module dram_bit_array #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (!rst_n) cells <= '0;
    else if (wr_en) cells[wr_idx] <= wr_bit;
  end

  assign rd_bit = cells[rd_idx];

  // R5 / R6: a requested write is visible in the named cell one clock later
  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cells[$past(wr_idx)] == $past(wr_bit));
endmodule

// File: rtl/dram_access_ctrl.sv
module dram_access_ctrl
  import dram_pkg::*;
#(
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int ADDR_W     = 4,
  parameter int ACCESS_CYC = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ras_s,
  input  logic                   cas_s,
  input  logic                   we_s,
  input  logic [ADDR_W-1:0]      addr_s,
  input  logic                   ras_fall,
  input  logic                   cas_fall,
  input  logic                   we_fall,
  output logic                   wr_en,
  output logic [ROW_W+COL_W-1:0] wr_idx,
  output logic [ROW_W+COL_W-1:0] acc_idx,
  output logic                   q_oe
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int CNT_W = $clog2(ACCESS_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(ACCESS_CYC);

  logic [ROW_W-1:0] row_r;
  logic [CNT_W-1:0] wait_cnt;
  cyc_kind_t        kind;
  logic             oe_r;
  logic             col_go;
  logic             late_wr;
  logic [IDX_W-1:0] new_idx;

  // column capture is only meaningful with the row strobe low
  assign col_go  = cas_fall & ~ras_s;
  assign new_idx = {row_r, addr_s[COL_W-1:0]};
  assign late_wr = we_fall & ~cas_s & ~cas_fall & (kind == CYC_READ);

  assign wr_en  = (col_go & ~we_s) | late_wr;
  assign wr_idx = col_go ? new_idx : acc_idx;
  assign q_oe   = oe_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_r <= '0;
    end else if (ras_fall) begin
      row_r <= addr_s[ROW_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind     <= CYC_IDLE;
      acc_idx  <= '0;
      wait_cnt <= '0;
      oe_r     <= 1'b0;
    end else if (col_go) begin
      kind     <= we_s ? CYC_READ : CYC_EWRITE;
      acc_idx  <= new_idx;
      wait_cnt <= '0;
      oe_r     <= 1'b0;
    end else if (cas_s) begin
      kind     <= CYC_IDLE;
      wait_cnt <= '0;
      oe_r     <= 1'b0;
    end else begin
      if (wait_cnt != CNT_DONE) wait_cnt <= wait_cnt + 1'b1;
      oe_r <= (kind == CYC_READ) && (wait_cnt == CNT_DONE);
    end
  end

  assert_q_off_cas_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_s && $past(cas_s)) |-> !q_oe);

  assert_oe_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    q_oe |-> (kind == CYC_READ));

  assert_early_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_EWRITE) |-> !q_oe);

  assert_write_needs_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cas_s);

  assert_no_access_ras_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && ras_s) |=> (kind == CYC_IDLE));

  assert_oe_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_oe && !cas_s) |=> q_oe);
endmodule

// File: rtl/dram_x1_model.sv
module dram_x1_model #(
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int ACCESS_CYC = 3,
  parameter int ADDR_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              d,
  output logic              q,
  output logic              q_oe
);
  localparam int IDX_W = ROW_W + COL_W;

  logic              ras_s, cas_s, we_s, d_s;
  logic [ADDR_W-1:0] addr_s;
  logic              ras_fall, cas_fall, we_fall;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, acc_idx;
  logic              rd_bit;

  dram_pin_sampler #(.ADDR_W(ADDR_W)) sampler_i (
    .clk(clk), .rst_n(rst_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .d(d),
    .ras_s(ras_s), .cas_s(cas_s), .we_s(we_s), .addr_s(addr_s), .d_s(d_s),
    .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall)
  );

  dram_access_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .ACCESS_CYC(ACCESS_CYC)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .ras_s(ras_s), .cas_s(cas_s), .we_s(we_s), .addr_s(addr_s),
    .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall),
    .wr_en(wr_en), .wr_idx(wr_idx), .acc_idx(acc_idx), .q_oe(q_oe)
  );

  dram_bit_array #(.IDX_W(IDX_W)) array_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_bit(d_s),
    .rd_idx(acc_idx), .rd_bit(rd_bit)
  );

  assign q = q_oe & rd_bit;
endmodule

// File: tb/dram_x1_model_tb.sv
`timescale 1ns/1ps
module dram_x1_model_tb_top;
  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int ACC   = 3;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, d = 1'b0;
  logic [AW-1:0] addr = '0;
  logic q, q_oe;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dram_x1_model #(.ROW_W(ROW_W), .COL_W(COL_W), .ACCESS_CYC(ACC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .d(d), .q(q), .q_oe(q_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic open_row(input int r);
    addr = AW'(r); ras_n = 1'b0; tick(2);
  endtask

  task automatic close_row();
    cas_n = 1'b1; we_n = 1'b1; tick(2); ras_n = 1'b1; tick(3);
  endtask

  task automatic cas_write(input int c, input bit v);
    addr = AW'(c); d = v; we_n = 1'b0; cas_n = 1'b0;
    tick(ACC + 3);
    chk(q_oe == 1'b0, "R5 early write keeps q_oe low", int'(q_oe), 0);
    cas_n = 1'b1; we_n = 1'b1; tick(3);
  endtask

  task automatic cas_read(input int c, output bit v);
    addr = AW'(c); we_n = 1'b1; cas_n = 1'b0;
    tick(1);
    chk(q_oe == 1'b0, "R4 q_oe low during access time", int'(q_oe), 0);
    tick(ACC + 2);
    chk(q_oe == 1'b1, "R4 q_oe high after access time", int'(q_oe), 1);
    v = q;
    cas_n = 1'b1; tick(3);
    chk(q_oe == 1'b0, "R3 q_oe low with cas_n high", int'(q_oe), 0);
  endtask

  task automatic read_cell(input int r, input int c, input bit exp, input string req);
    bit v;
    open_row(r);
    cas_read(c, v);
    chk(v == exp, req, int'(v), int'(exp));
    close_row();
  endtask

  task automatic t_reset();
    chk(q_oe == 1'b0, "R1 q_oe after reset", int'(q_oe), 0);
    read_cell(0, 0, 1'b0, "R1 cell 0,0 cleared");
    read_cell(15, 15, 1'b0, "R1 cell 15,15 cleared");
  endtask

  task automatic t_early_write();
    open_row(2);
    cas_write(5, 1'b1);
    close_row();
    read_cell(2, 5, 1'b1, "R5 early write stored");
    read_cell(5, 2, 1'b0, "R2 row/column swap selects other cell");
  endtask

  task automatic t_ras_release();
    open_row(2);
    addr = 4'd5; cas_n = 1'b0; tick(ACC + 3);
    ras_n = 1'b1; tick(4);
    chk(q_oe == 1'b1, "R4 q held after ras_n rises", int'(q_oe), 1);
    chk(q == 1'b1, "R4 q data after ras_n rises", int'(q), 1);
    cas_n = 1'b1; tick(3);
    chk(q_oe == 1'b0, "R3 q off after cas_n rises", int'(q_oe), 0);
  endtask

  task automatic t_late_write();
    open_row(7);
    addr = 4'd3; we_n = 1'b1; cas_n = 1'b0; tick(ACC + 3);
    chk(q_oe == 1'b1 && q == 1'b0, "R6 read phase shows old 0", int'(q), 0);
    d = 1'b1; we_n = 1'b0; tick(3);
    chk(q_oe == 1'b1, "R6 q_oe stays on in late write", int'(q_oe), 1);
    chk(q == 1'b1, "R6 q shows new data", int'(q), 1);
    close_row();
    read_cell(7, 3, 1'b1, "R6 late write stored");
  endtask

  task automatic t_refresh();
    addr = 4'd2; d = 1'b0; we_n = 1'b0; ras_n = 1'b0; tick(ACC + 4);
    chk(q_oe == 1'b0, "R7 refresh leaves q off", int'(q_oe), 0);
    ras_n = 1'b1; we_n = 1'b1; tick(3);
    read_cell(2, 5, 1'b1, "R7 refresh keeps data");
  endtask

  task automatic t_page();
    bit v;
    open_row(9);
    cas_write(1, 1'b1);
    cas_write(4, 1'b1);
    cas_read(1, v);
    chk(v == 1'b1, "R8 page read col 1", int'(v), 1);
    cas_read(2, v);
    chk(v == 1'b0, "R8 page read col 2", int'(v), 0);
    cas_read(4, v);
    chk(v == 1'b1, "R8 page read col 4", int'(v), 1);
    close_row();
  endtask

  task automatic t_cas_no_ras();
    open_row(9);
    ras_n = 1'b1; tick(3);
    addr = 4'd6; d = 1'b1; we_n = 1'b0; cas_n = 1'b0; tick(ACC + 3);
    chk(q_oe == 1'b0, "R9 no output without ras_n", int'(q_oe), 0);
    cas_n = 1'b1; we_n = 1'b1; tick(3);
    addr = 4'd6; cas_n = 1'b0; tick(ACC + 3);
    chk(q_oe == 1'b0, "R9 no read without ras_n", int'(q_oe), 0);
    cas_n = 1'b1; tick(3);
    read_cell(9, 6, 1'b0, "R9 no write without ras_n");
  endtask

  task automatic t_hidden();
    open_row(2);
    addr = 4'd5; cas_n = 1'b0; tick(ACC + 3);
    ras_n = 1'b1; tick(2);
    addr = 4'd0; ras_n = 1'b0; tick(3);
    ras_n = 1'b1; tick(2);
    chk(q_oe == 1'b1, "R10 q_oe through hidden refresh", int'(q_oe), 1);
    chk(q == 1'b1, "R10 q keeps original cell", int'(q), 1);
    cas_n = 1'b1; tick(3);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_early_write();
    t_ras_release();
    t_late_write();
    t_refresh();
    t_page();
    t_cas_no_ras();
    t_hidden();
    report();
  end

  initial begin
    #(200000 * 5);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    report();
  end
endmodule